// File: doc/BRIEF.md
# Interrupt-Free Event Trace Sampler

The block gathers performance-event information into memory without ever interrupting software. Two 64-bit configuration words set it up. The control word enables the block, picks one of two modes and gives the memory address. The sampling word gives a reload value, a tick source, two event selects and a buffer-size code. A down-counting sample timer runs from the configured tick source. Each time the timer expires, the block builds a 32-byte record and issues it as one wide write on a valid/ready port. The record holds the program counter, the two selected event counts and a sequence number.

In trace mode, records fill a bounded buffer that starts at the configured address, one after another. Each record clears the event counts. When the last slot of the buffer has been written, the block goes quiet and raises no error. In accumulation mode, every record overwrites the same location and the counts keep growing, so software can read current totals at any time. A write that is stalled by the memory side is held. Any expiry that happens while a write is stalled is lost and counted.

Top module: `trace_sampler`

## Requirements
- R1: After a synchronous active-low reset the block is disabled, `mem_valid` is 0 and `drop_cnt` is 0.
- R2: The control word is numbered MSB first, so field bit k is data bit 63-k. Bit 0 (data[63]) enables the block. Bit 1 (data[62]) picks the mode: 0 is accumulation, 1 is trace. Bits 8..50 (data[55:13]) give the byte address bits 55:13, and all other address bits are zero. Every other bit of the control word is ignored.
- R3: The sampling word is numbered MSB first. The fields are: tick source at data[63:62], 32-bit reload value L at data[61:30], event select A at data[29:23], event select B at data[22:16], and buffer-size code n at data[15:13]. Bits data[12:0] are ignored.
- R4: Tick source 0 or 3 ticks the timer every running cycle. Source 1 ticks only in cycles where the event picked by select A is high. Source 2 ticks only in cycles where the event picked by select B is high.
- R5: The timer is loaded with L and counts down one per tick. A tick that finds the timer at 1 or 0 is an expiry, and the timer reloads to L. Expiries are therefore max(L,1) ticks apart. A sampling-word write reloads the timer with the new L.
- R6: Each record is one write of `mem_data`, made of four 64-bit words. Bits [63:0] hold the PC in the expiry cycle. Bits [127:64] hold count A and bits [191:128] hold count B, each including that cycle's event. Bits [255:192] hold a sequence number that starts at 0 after a restart.
- R7: Each count increases by one in every running cycle where its selected event is high. In trace mode a count is zeroed when a record is issued. In accumulation mode it keeps growing.
- R8: In trace mode, record k after a restart is written to the base address plus 32·k.
- R9: The trace buffer holds (4096 << n) bytes. After the record that fills it, the block issues no further write until the next control-word write.
- R10: In accumulation mode every record is written to the base address, and the block never stops.
- R11: While `mem_valid` is high and `mem_ready` is low, the address and data are held. An expiry during such a stall issues nothing, adds one to `drop_cnt` and leaves the counts uncleared.
- R12: A control-word write restarts the block. It clears the buffer pointer, the stopped state, the sequence number and both counts, and it reloads the timer. While the block is disabled it neither counts nor writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base_we | input | 1 | Write strobe for the control word |
| cfg_base_wdata | input | 64 | Control word value |
| cfg_trace_we | input | 1 | Write strobe for the sampling word |
| cfg_trace_wdata | input | 64 | Sampling word value |
| evt_in | input | 128 | One pulse line per event source |
| pc_in | input | 64 | Current program counter |
| mem_valid | output | 1 | Record write pending |
| mem_ready | input | 1 | Memory side accepts the write |
| mem_addr | output | 64 | Byte address of the record |
| mem_data | output | 256 | Record contents |
| drop_cnt | output | 32 | Number of expiries lost to stalls |

## Verification
The assertions assume that `mem_ready` may change freely, and that software never writes both configuration words in the same cycle. When both are written in one cycle, the restart is meant to take the new reload value. The assertions also treat the stopped state as reachable only in trace mode, which holds because any change of mode passes through a restart. The stimulus writes at most one configuration word per cycle. It drives random event vectors and random ready patterns only at falling edges. Every phase begins with a sampling-word write followed by a control-word write, so each phase starts from a defined restart.

// File: rtl/ts_pkg.sv
// Package ts_pkg
// Shared field positions, widths and types for the trace sampler.
// Field positions are given MSB first (field bit k sits at data bit REG_W-1-k).
package ts_pkg;
    localparam int REG_W          = 64;
    localparam int SEL_W          = 7;
    localparam int EVT_N          = 1 << SEL_W;
    localparam int LOAD_W         = 32;
    localparam int BSZ_W          = 3;
    localparam int TICK_W         = 2;
    localparam int REC_BYTES      = 32;
    localparam int BUF_MIN_LOG2   = 12;
    localparam int BUF_MIN_BYTES  = 1 << BUF_MIN_LOG2;
    localparam int OFF_W          = BUF_MIN_LOG2 + (1 << BSZ_W);

    // control word field positions (MSB-first numbering)
    localparam int CW_EN_POS      = 0;
    localparam int CW_MODE_POS    = 1;
    localparam int CW_ADDR_FIRST  = 8;
    localparam int CW_ADDR_LAST   = 50;
    localparam int ADDR_FLD_W     = CW_ADDR_LAST - CW_ADDR_FIRST + 1;
    localparam int ADDR_LSB       = REG_W - 1 - CW_ADDR_LAST;

    // sampling word field positions (MSB-first numbering)
    localparam int SW_TICK_FIRST  = 0;
    localparam int SW_LOAD_FIRST  = SW_TICK_FIRST + TICK_W;
    localparam int SW_SELA_FIRST  = SW_LOAD_FIRST + LOAD_W;
    localparam int SW_SELB_FIRST  = SW_SELA_FIRST + SEL_W;
    localparam int SW_BSZ_FIRST   = SW_SELB_FIRST + SEL_W;
    localparam int SW_USED_BITS   = SW_BSZ_FIRST + BSZ_W;

    typedef enum logic {
        MODE_ACCUM = 1'b0,
        MODE_TRACE = 1'b1
    } mode_e;

    typedef enum logic [TICK_W-1:0] {
        TICK_CYCLE     = 2'd0,
        TICK_EVT_A     = 2'd1,
        TICK_EVT_B     = 2'd2,
        TICK_CYCLE_ALT = 2'd3
    } tick_e;

    typedef struct packed {
        logic                  en;
        mode_e                 mode;
        logic [ADDR_FLD_W-1:0] addr_fld;
    } ctrl_cfg_t;

    typedef struct packed {
        tick_e              tick;
        logic [LOAD_W-1:0]  load;
        logic [SEL_W-1:0]   sel_a;
        logic [SEL_W-1:0]   sel_b;
        logic [BSZ_W-1:0]   bsz;
    } samp_cfg_t;
endpackage

// File: rtl/ts_cfg_regs.sv
// Module ts_cfg_regs
// Holds the decoded control and sampling words. Reserved bits are dropped at
// decode time. Assumes both words are never written in the same cycle;
// if they are, the reload value is taken from the new sampling word.
module ts_cfg_regs
    import ts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [REG_W-1:0]  ctrl_wdata,
    input  logic              samp_we,
    input  logic [REG_W-1:0]  samp_wdata,
    output ctrl_cfg_t         ctrl_q,
    output samp_cfg_t         samp_q,
    output logic              restart,
    output logic              reload,
    output logic [LOAD_W-1:0] reload_val
);
    ctrl_cfg_t ctrl_d;
    samp_cfg_t samp_d;
    logic      unused_resv;

    // decode the control word fields from their MSB-first positions
    always_comb begin
        ctrl_d.en       = ctrl_wdata[REG_W-1-CW_EN_POS];
        ctrl_d.mode     = mode_e'(ctrl_wdata[REG_W-1-CW_MODE_POS]);
        ctrl_d.addr_fld = ctrl_wdata[REG_W-1-CW_ADDR_FIRST -: ADDR_FLD_W];
    end

    // decode the sampling word fields from their MSB-first positions
    always_comb begin
        samp_d.tick  = tick_e'(samp_wdata[REG_W-1-SW_TICK_FIRST -: TICK_W]);
        samp_d.load  = samp_wdata[REG_W-1-SW_LOAD_FIRST -: LOAD_W];
        samp_d.sel_a = samp_wdata[REG_W-1-SW_SELA_FIRST -: SEL_W];
        samp_d.sel_b = samp_wdata[REG_W-1-SW_SELB_FIRST -: SEL_W];
        samp_d.bsz   = samp_wdata[REG_W-1-SW_BSZ_FIRST -: BSZ_W];
    end

    // reserved bits are deliberately discarded
    assign unused_resv = ^{ctrl_wdata[REG_W-1-CW_MODE_POS-1 : REG_W-CW_ADDR_FIRST],
                           ctrl_wdata[ADDR_LSB-1:0],
                           samp_wdata[REG_W-1-SW_USED_BITS:0]};

    // configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            samp_q <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_d;
            if (samp_we) samp_q <= samp_d;
        end
    end

    assign restart    = ctrl_we;
    assign reload     = ctrl_we | samp_we;
    assign reload_val = samp_we ? samp_d.load : samp_q.load;
endmodule

// File: rtl/ts_sample_timer.sv
// Module ts_sample_timer
// Reloadable down counter that decides when a sample is due. It ticks each
// running cycle or on one selected event. A tick that finds the counter at 1
// or 0 is an expiry, and the counter then reloads. Assumes run is low in any
// cycle where reload is high.
module ts_sample_timer
    import ts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  tick_e             tick_sel,
    input  logic              hit_a,
    input  logic              hit_b,
    input  logic              reload,
    input  logic [LOAD_W-1:0] reload_val,
    input  logic [LOAD_W-1:0] load_q,
    output logic              expire
);
    logic [LOAD_W-1:0] cnt_q;
    logic              tick;

    // choose the tick source
    always_comb begin
        unique case (tick_sel)
            TICK_EVT_A: tick = hit_a;
            TICK_EVT_B: tick = hit_b;
            default:    tick = 1'b1;
        endcase
    end

    assign expire = run && tick && (cnt_q <= LOAD_W'(1));

    // count down, reload on expiry or on a configuration write
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (reload)      cnt_q <= reload_val;
        else if (expire)      cnt_q <= load_q;
        else if (run && tick) cnt_q <= cnt_q - LOAD_W'(1);
    end

    // the counter never exceeds the configured reload value
    p_timer_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= load_q);
endmodule

// File: rtl/ts_event_counters.sv
// Module ts_event_counters
// Per-channel event counters. Each channel counts running cycles where its
// selected event line is high. It offers the value including the current
// cycle, and it is cleared on restart or when a trace record takes it.
module ts_event_counters
    import ts_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [EVT_N-1:0]             evt,
    input  logic [NUM_CH-1:0][SEL_W-1:0] sel,
    input  logic                         run,
    input  logic                         clear,
    input  logic                         take,
    output logic [NUM_CH-1:0]            hit,
    output logic [NUM_CH-1:0][CNT_W-1:0] cnt_next
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [CNT_W-1:0] cnt_q;

        // selected event line for this channel
        assign hit[c]      = evt[sel[c]];
        assign cnt_next[c] = cnt_q + CNT_W'(run && hit[c]);

        // counter register with clear on restart or record capture
        always_ff @(posedge clk) begin
            if (!rst_n || clear || take) cnt_q <= '0;
            else if (run)                cnt_q <= cnt_next[c];
        end
    end
endmodule

// File: rtl/ts_record_writer.sv
// Module ts_record_writer
// Turns expiries into record writes. It holds a stalled write, counts
// expiries lost to stalls, advances the trace pointer and stops quietly when
// the buffer is full. Assumes expire is never high in a restart cycle.
module ts_record_writer
    import ts_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int ADDR_W = 64,
    parameter int DROP_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                expire,
    input  mode_e               mode,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [BSZ_W-1:0]    bsz,
    input  logic [WORD_W-1:0]   pc,
    input  logic [WORD_W-1:0]   cnt_a,
    input  logic [WORD_W-1:0]   cnt_b,
    input  logic                mem_ready,
    output logic                mem_valid,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [4*WORD_W-1:0] mem_data,
    output logic [DROP_W-1:0]   drop_cnt,
    output logic                stopped,
    output logic                take
);
    logic [OFF_W-1:0]  off_q;
    logic [OFF_W-1:0]  off_next;
    logic [OFF_W-1:0]  buf_bytes;
    logic [WORD_W-1:0] seq_q;
    logic              can_cap;
    logic              cap;
    logic              lost;

    assign can_cap   = !mem_valid || mem_ready;
    assign cap       = expire && can_cap;
    assign lost      = expire && !can_cap;
    assign take      = cap && (mode == MODE_TRACE);
    assign buf_bytes = OFF_W'(BUF_MIN_BYTES) << bsz;
    assign off_next  = off_q + OFF_W'(REC_BYTES);

    // output register: load a record, or retire it when accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_addr  <= '0;
            mem_data  <= '0;
        end else if (cap) begin
            mem_valid <= 1'b1;
            mem_addr  <= (mode == MODE_TRACE) ? base_addr + ADDR_W'(off_q) : base_addr;
            mem_data  <= {seq_q, cnt_b, cnt_a, pc};
        end else if (mem_ready) begin
            mem_valid <= 1'b0;
        end
    end

    // buffer pointer, sequence number and stopped state
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            off_q   <= '0;
            seq_q   <= '0;
            stopped <= 1'b0;
        end else if (cap) begin
            seq_q <= seq_q + WORD_W'(1);
            if (mode == MODE_TRACE) begin
                off_q <= off_next;
                if (off_next >= buf_bytes) stopped <= 1'b1;
            end
        end
    end

    // count expiries lost to a stalled write
    always_ff @(posedge clk) begin
        if (!rst_n)    drop_cnt <= '0;
        else if (lost) drop_cnt <= drop_cnt + DROP_W'(1);
    end

    // a stalled write keeps its address and data
    p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // losses are only counted while a write is stalled
    p_drop_in_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && !mem_ready) |=> $stable(drop_cnt));

    // a full buffer issues no new write until restart
    p_quiet_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !restart && !mem_valid) |=> !mem_valid);
endmodule

// File: rtl/trace_sampler.sv
// Module trace_sampler
// Top level of the interrupt-free event trace sampler. It joins the
// configuration registers, the sample timer, the event counters and the
// record writer. Assumes at most one configuration word is written per cycle.
module trace_sampler
    import ts_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int ADDR_W = 64,
    parameter int DROP_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_base_we,
    input  logic [REG_W-1:0]    cfg_base_wdata,
    input  logic                cfg_trace_we,
    input  logic [REG_W-1:0]    cfg_trace_wdata,
    input  logic [EVT_N-1:0]    evt_in,
    input  logic [WORD_W-1:0]   pc_in,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [4*WORD_W-1:0] mem_data,
    output logic [DROP_W-1:0]   drop_cnt
);
    localparam int NUM_CH = 2;

    ctrl_cfg_t                  ctrl_q;
    samp_cfg_t                  samp_q;
    logic                       restart;
    logic                       reload;
    logic [LOAD_W-1:0]          reload_val;
    logic                       run;
    logic                       expire;
    logic                       stopped;
    logic                       take;
    logic [ADDR_W-1:0]          base_addr;
    logic [NUM_CH-1:0]          hit;
    logic [NUM_CH-1:0][SEL_W-1:0]  sel;
    logic [NUM_CH-1:0][WORD_W-1:0] cnt_next;

    // run only when enabled, not frozen by a full trace buffer, no config write
    assign run = ctrl_q.en && !((ctrl_q.mode == MODE_TRACE) && stopped) && !reload;
    assign base_addr = ADDR_W'(ctrl_q.addr_fld) << ADDR_LSB;
    assign sel[0] = samp_q.sel_a;
    assign sel[1] = samp_q.sel_b;

    ts_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (cfg_base_we),
        .ctrl_wdata (cfg_base_wdata),
        .samp_we    (cfg_trace_we),
        .samp_wdata (cfg_trace_wdata),
        .ctrl_q     (ctrl_q),
        .samp_q     (samp_q),
        .restart    (restart),
        .reload     (reload),
        .reload_val (reload_val)
    );

    ts_event_counters #(.NUM_CH(NUM_CH), .CNT_W(WORD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_in),
        .sel      (sel),
        .run      (run),
        .clear    (restart),
        .take     (take),
        .hit      (hit),
        .cnt_next (cnt_next)
    );

    ts_sample_timer u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick_sel   (samp_q.tick),
        .hit_a      (hit[0]),
        .hit_b      (hit[1]),
        .reload     (reload),
        .reload_val (reload_val),
        .load_q     (samp_q.load),
        .expire     (expire)
    );

    ts_record_writer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DROP_W(DROP_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .expire    (expire),
        .mode      (ctrl_q.mode),
        .base_addr (base_addr),
        .bsz       (samp_q.bsz),
        .pc        (pc_in),
        .cnt_a     (cnt_next[0]),
        .cnt_b     (cnt_next[1]),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .drop_cnt  (drop_cnt),
        .stopped   (stopped),
        .take      (take)
    );

    // a disabled block starts no write
    p_idle_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !mem_valid) |=> !mem_valid);
endmodule

// File: tb/tb_trace_sampler.sv
// Bench for trace_sampler: a behavioural model runs alongside the design and
// is compared at every falling edge, with directed checks per phase.
module tb_trace_sampler;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_base_we = 1'b0;
    logic [63:0]  cfg_base_wdata = '0;
    logic         cfg_trace_we = 1'b0;
    logic [63:0]  cfg_trace_wdata = '0;
    logic [127:0] evt_in = '0;
    logic [63:0]  pc_in = '0;
    logic         mem_valid;
    logic         mem_ready = 1'b1;
    logic [63:0]  mem_addr;
    logic [255:0] mem_data;
    logic [31:0]  drop_cnt;

    trace_sampler dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_base_we(cfg_base_we), .cfg_base_wdata(cfg_base_wdata),
        .cfg_trace_we(cfg_trace_we), .cfg_trace_wdata(cfg_trace_wdata),
        .evt_in(evt_in), .pc_in(pc_in),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .drop_cnt(drop_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    string tag = "R1";
    bit    cmp_on = 1'b0;

    task automatic chk(string t, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // ---------------- behavioural model ----------------
    logic         m_en, m_mode, m_stop, m_v;
    logic [63:0]  m_base, m_addr, m_seq, m_c1, m_c2, m_off;
    logic [255:0] m_data;
    logic [1:0]   m_ts;
    logic [31:0]  m_load, m_tmr, m_drop;
    logic [6:0]   m_s1, m_s2;
    logic [2:0]   m_bsz;

    always @(posedge clk) begin
        logic can, cap, h1, h2, tk;
        logic [63:0] n1, n2;
        if (!rst_n) begin
            m_en = 0; m_mode = 0; m_stop = 0; m_v = 0; m_base = 0; m_addr = 0;
            m_seq = 0; m_c1 = 0; m_c2 = 0; m_off = 0; m_data = 0; m_ts = 0;
            m_load = 0; m_tmr = 0; m_drop = 0; m_s1 = 0; m_s2 = 0; m_bsz = 0;
        end else begin
            can = !m_v || mem_ready;
            cap = 0;
            if (cfg_base_we) begin
                m_en = cfg_base_wdata[63];
                m_mode = cfg_base_wdata[62];
                m_base = cfg_base_wdata & 64'h00FF_FFFF_FFFF_E000;
                m_off = 0; m_seq = 0; m_stop = 0; m_c1 = 0; m_c2 = 0;
                m_tmr = m_load;
            end else if (cfg_trace_we) begin
                m_ts = cfg_trace_wdata[63:62];
                m_load = cfg_trace_wdata[61:30];
                m_s1 = cfg_trace_wdata[29:23];
                m_s2 = cfg_trace_wdata[22:16];
                m_bsz = cfg_trace_wdata[15:13];
                m_tmr = m_load;
            end else if (m_en && !(m_mode && m_stop)) begin
                h1 = evt_in[m_s1];
                h2 = evt_in[m_s2];
                n1 = m_c1 + 64'(h1);
                n2 = m_c2 + 64'(h2);
                tk = (m_ts == 2'd1) ? h1 : (m_ts == 2'd2) ? h2 : 1'b1;
                if (tk) begin
                    if (m_tmr <= 1) begin
                        m_tmr = m_load;
                        if (can) begin
                            cap = 1;
                            m_addr = m_mode ? m_base + m_off : m_base;
                            m_data = {m_seq, n2, n1, pc_in};
                            m_seq = m_seq + 1;
                            if (m_mode) begin
                                m_off = m_off + 32;
                                if (m_off >= (64'd4096 << m_bsz)) m_stop = 1;
                                n1 = 0; n2 = 0;
                            end
                        end else begin
                            m_drop = m_drop + 1;
                        end
                    end else begin
                        m_tmr = m_tmr - 1;
                    end
                end
                m_c1 = n1; m_c2 = n2;
            end
            if (cap) m_v = 1;
            else if (mem_ready) m_v = 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(tag, 256'(mem_valid), 256'(m_v));
            if (m_v) begin
                chk(tag, 256'(mem_addr), 256'(m_addr));
                chk(tag, mem_data, m_data);
            end
            chk(tag, 256'(drop_cnt), 256'(m_drop));
        end
    end

    // handshake monitor
    int          hs_cnt = 0;
    int          cyc = 0;
    int          t1, t2;
    logic [63:0] a1, a2;
    always @(posedge clk) begin
        cyc++;
        if (rst_n && mem_valid && mem_ready) begin
            hs_cnt++;
            if (hs_cnt == 1) begin a1 = mem_addr; t1 = cyc; end
            if (hs_cnt == 2) begin a2 = mem_addr; t2 = cyc; end
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive_idle(int ready_pct);
        cfg_base_we = 0;
        cfg_trace_we = 0;
        evt_in = {$urandom, $urandom, $urandom, $urandom};
        pc_in = {$urandom, $urandom};
        mem_ready = (($urandom % 100) < ready_pct);
    endtask

    task automatic run_cycles(int n, int ready_pct);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drive_idle(ready_pct);
        end
    endtask

    task automatic wr_trace(logic [1:0] ts, logic [31:0] ld, logic [6:0] s1, logic [6:0] s2, logic [2:0] bsz);
        @(negedge clk);
        drive_idle(100);
        cfg_trace_we = 1;
        cfg_trace_wdata = {ts, ld, s1, s2, bsz, 13'h1FFF};
    endtask

    task automatic wr_base(logic en, logic mode, logic [42:0] addr);
        @(negedge clk);
        drive_idle(100);
        cfg_base_we = 1;
        cfg_base_wdata = {en, mode, 2'b11, 3'b101, 1'b1, addr, 13'h1FFF};
    endtask

    initial begin
        #(CLK_PERIOD * 300000);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int quiet;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", 256'(mem_valid), 256'(0));
        chk("R1", 256'(drop_cnt), 256'(0));
        rst_n = 1;
        cmp_on = 1;

        // R6 / R2 / R5 / R8 / R9: trace mode, every-cycle tick, 4 KiB buffer
        tag = "R6";
        wr_trace(2'd0, 32'd5, 7'd3, 7'd70, 3'd0);
        wr_base(1'b1, 1'b1, 43'h123);
        @(negedge clk); drive_idle(100); hs_cnt = 0;
        run_cycles(128 * 5 + 100, 100);
        chk("R2", 256'(a1), 256'(64'h123 << 13));
        chk("R8", 256'(a2 - a1), 256'(32));
        chk("R5", 256'(t2 - t1), 256'(5));
        chk("R9", 256'(hs_cnt), 256'(128));

        // R11: stalls with a short period, 8 KiB buffer
        tag = "R11";
        wr_trace(2'd0, 32'd2, 7'd10, 7'd11, 3'd1);
        wr_base(1'b1, 1'b1, 43'h40);
        run_cycles(600, 60);
        chk("R11", 256'(drop_cnt != 0), 256'(1));

        // R3: extreme selects in trace mode
        tag = "R3";
        wr_trace(2'd0, 32'd3, 7'd127, 7'd0, 3'd0);
        wr_base(1'b1, 1'b1, 43'h7);
        run_cycles(200, 100);

        // R4: accumulation, tick on event A
        tag = "R4";
        wr_trace(2'd1, 32'd4, 7'd20, 7'd21, 3'd0);
        wr_base(1'b1, 1'b0, 43'h55);
        run_cycles(300, 80);

        // R10: accumulation, tick on event B
        tag = "R10";
        wr_trace(2'd2, 32'd3, 7'd30, 7'd99, 3'd0);
        wr_base(1'b1, 1'b0, 43'h99);
        @(negedge clk); drive_idle(100); hs_cnt = 0;
        run_cycles(300, 100);
        chk("R10", 256'(a1), 256'(64'h99 << 13));
        chk("R10", 256'(a2), 256'(64'h99 << 13));

        // R7: accumulation, load 0 and tick source 3
        tag = "R7";
        wr_trace(2'd3, 32'd0, 7'd64, 7'd65, 3'd0);
        wr_base(1'b1, 1'b0, 43'h3);
        run_cycles(200, 70);

        // R12: disable, then restart a partly filled trace buffer
        tag = "R12";
        wr_trace(2'd0, 32'd3, 7'd1, 7'd2, 3'd0);
        wr_base(1'b1, 1'b1, 43'h200);
        run_cycles(60, 100);
        wr_base(1'b0, 1'b1, 43'h200);
        run_cycles(3, 100);
        quiet = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (mem_valid) quiet++;
            drive_idle(100);
        end
        chk("R12", 256'(quiet), 256'(0));
        wr_base(1'b1, 1'b1, 43'h200);
        @(negedge clk); drive_idle(100); hs_cnt = 0;
        run_cycles(50, 100);
        chk("R12", 256'(a1), 256'(64'h200 << 13));

        cmp_on = 0;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule